// File: doc/BRIEF.md
# Packed logical right shifter

This block is a purely combinational SIMD shift unit. It divides a vector into equal elements of 16, 32 or 64 bits and moves every element right by one common bit count. Zeros fill the vacated high bits of each element, and no bit crosses from one element into the next. The count comes from one of two places: an 8-bit immediate, or the low 64 bits of a 128-bit count operand.

A mode input decides what happens to the upper half of the 256-bit result. The legacy mode copies the prior destination's upper half through unchanged. The narrow zeroing mode clears the upper half. The wide mode shifts both 128-bit halves by the same count.

Instruction decode and operand fetch are handled elsewhere. The caller places the vector to shift on `src`. In the legacy mode, that is normally the old destination value.

Top module: `vec_srl_unit`

## Requirements
- R1: `esize` selects the element width: 2'b00 gives 16 bits, 2'b01 gives 32 bits and 2'b10 gives 64 bits. Every element of `src` is shifted right by the same count, and no bit moves from one element into its neighbour.
- R2: When the count is at least 1 and below the element width, the top bit of every shifted element is zero.
- R3: When the count is greater than the element width minus one (15, 31 or 63), every computed element is zero.
- R4: When `use_imm` is 0, the count is `cnt_vec[63:0]`. Bits 127:64 of `cnt_vec` have no effect on `res`.
- R5: When `use_imm` is 1, the count is `imm` zero-extended to 64 bits, and `cnt_vec` has no effect on `res`.
- R6: In mode 2'b00 (legacy), `res[127:0]` is the shifted low half of `src`, and `res[255:128]` equals `prior[255:128]`.
- R7: In mode 2'b01 (narrow zeroing), `res[127:0]` is the shifted low half of `src`, and `res[255:128]` is zero.
- R8: In mode 2'b10 (wide), all 256 bits of `src` are shifted, using one count for both halves.
- R9: Mode 2'b11 gives an all-zero `res`. An `esize` of 2'b11 gives zero for every computed element; in the legacy mode, the upper half still comes from `prior`.
- R10: The count is compared over its full 64 bits. For example, a count of 2^32+1 zeroes every element and is never truncated to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src | input | 256 | Vector to shift |
| prior | input | 256 | Prior destination; its upper half is used in the legacy mode |
| cnt_vec | input | 128 | Count operand; only bits 63:0 are used |
| imm | input | 8 | Immediate count |
| use_imm | input | 1 | 1 selects the immediate count, 0 selects the count operand |
| esize | input | 2 | Element width select |
| mode | input | 2 | Upper-half mode |
| res | output | 256 | Result |

## Verification
The bench builds the unit with its default parameters: a 256-bit vector and a 64-bit count. This lets it reach every element width, all four modes, and counts larger than 32 bits. Directed cases sweep the count through width-1, width and width+1 for each element size, and also try 2^32+1 and all-ones. Further cases change only the ignored operand bits and check that `res` stays the same. Seeded random vectors, with counts biased toward the boundaries, are compared against a bit-level reference model written separately from the RTL.

// File: rtl/vec_srl_unit.sv
module vec_srl_unit #(
  parameter int VEC_W = 256,
  parameter int CNT_W = 64,
  parameter int IMM_W = 8
) (
  input  logic [VEC_W-1:0]   src,
  input  logic [VEC_W-1:0]   prior,
  input  logic [VEC_W/2-1:0] cnt_vec,
  input  logic [IMM_W-1:0]   imm,
  input  logic               use_imm,
  input  logic [1:0]         esize,
  input  logic [1:0]         mode,
  output logic [VEC_W-1:0]   res
);
  localparam int HALF_W = VEC_W / 2;
  localparam int NSIZES = 3;

  logic [CNT_W-1:0]                 cnt;
  logic [NSIZES-1:0][VEC_W-1:0]     by_size;
  logic [NSIZES-1:0]                over;
  logic [VEC_W-1:0]                 shifted;
  logic                             unused_cnt_hi;

  assign cnt           = use_imm ? CNT_W'(imm) : cnt_vec[CNT_W-1:0];
  assign unused_cnt_hi = ^cnt_vec[HALF_W-1:CNT_W];

  for (genvar s = 0; s < NSIZES; s++) begin : g_size
    localparam int EW = 16 << s;
    localparam int NE = VEC_W / EW;
    localparam int SW = $clog2(EW);
    assign over[s] = cnt > CNT_W'(EW - 1);
    for (genvar e = 0; e < NE; e++) begin : g_elem
      assign by_size[s][e*EW +: EW] = over[s] ? '0 : (src[e*EW +: EW] >> cnt[SW-1:0]);
    end
  end

  always_comb begin
    case (esize)
      2'b00:   shifted = by_size[0];
      2'b01:   shifted = by_size[1];
      2'b10:   shifted = by_size[2];
      default: shifted = '0;
    endcase
  end

  always_comb begin
    case (mode)
      2'b00:   res = {prior[VEC_W-1:HALF_W], shifted[HALF_W-1:0]};
      2'b01:   res = {{HALF_W{1'b0}}, shifted[HALF_W-1:0]};
      2'b10:   res = shifted;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (esize == 2'b00 && cnt != '0 && cnt < CNT_W'(16)) begin
      for (int e = 0; e < VEC_W / 16; e++)
        a_r2_word_top_clear: assert (by_size[0][e*16 + 15] == 1'b0);
    end
    if (esize == 2'b01 && cnt > CNT_W'(31))
      a_r3_dword_over_zero: assert (res[HALF_W-1:0] == '0);
    if (esize == 2'b00 && cnt[CNT_W-1:32] != '0)
      a_r10_wide_count_zero: assert (res[HALF_W-1:0] == '0);
    if (mode == 2'b00)
      a_r6_legacy_keeps_high: assert (res[VEC_W-1:HALF_W] == prior[VEC_W-1:HALF_W]);
    if (mode == 2'b01)
      a_r7_narrow_high_zero: assert (res[VEC_W-1:HALF_W] == '0);
    if (mode == 2'b11 || (esize == 2'b11 && mode != 2'b00))
      a_r9_invalid_zero: assert (res == '0);
  end
endmodule

// File: tb/vec_srl_unit_test.sv
module vec_srl_unit_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [255:0] src, prior, res;
  logic [127:0] cnt_vec;
  logic [7:0]   imm;
  logic         use_imm;
  logic [1:0]   esize, mode;
  int checks = 0;
  int errors = 0;

  vec_srl_unit uut (
    .src(src), .prior(prior), .cnt_vec(cnt_vec), .imm(imm),
    .use_imm(use_imm), .esize(esize), .mode(mode), .res(res)
  );

  function automatic logic [255:0] model(input logic [255:0] s, input logic [255:0] p,
      input logic [127:0] cv, input logic [7:0] im, input logic ui,
      input logic [1:0] es, input logic [1:0] md);
    logic [63:0] c;
    logic [255:0] r;
    int w;
    c = ui ? {56'd0, im} : cv[63:0];
    w = (es == 2'b00) ? 16 : (es == 2'b01) ? 32 : (es == 2'b10) ? 64 : 0;
    r = '0;
    if (w != 0 && c < 64'(w)) begin
      for (int b = 0; b < 256; b++)
        if ((b % w) + int'(c) < w) r[b] = s[b + int'(c)];
    end
    case (md)
      2'b00: r[255:128] = p[255:128];
      2'b01: r[255:128] = '0;
      2'b10: ;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic apply_check(input string req);
    logic [255:0] exp;
    exp = model(src, prior, cnt_vec, imm, use_imm, esize, mode);
    @(posedge clk);
    #1;
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s: es=%0d md=%0d cnt=%h imm=%h ui=%0b act=%h exp=%h",
               req, esize, mode, cnt_vec[63:0], imm, use_imm, res, exp);
    end
  endtask

  task automatic drive(input logic [63:0] c, input logic [1:0] es, input logic [1:0] md);
    @(negedge clk);
    cnt_vec = {rnd256()[63:0], c};
    use_imm = 1'b0;
    esize = es;
    mode = md;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    src = '0; prior = '0; cnt_vec = '0; imm = '0; use_imm = 1'b0; esize = 2'b00; mode = 2'b10;
    apply_check("R1 zero input");

    src = rnd256(); prior = rnd256();
    // R1 R2 R3 R8: boundary counts per element width, wide mode
    for (int es = 0; es < 3; es++) begin
      int w;
      w = 16 << es;
      drive(64'(w - 1), 2'(es), 2'b10); apply_check("R1 R2 count width-1");
      drive(64'(w), 2'(es), 2'b10);     apply_check("R3 count width");
      drive(64'(w + 1), 2'(es), 2'b10); apply_check("R3 count width+1");
      drive(64'd1, 2'(es), 2'b10);      apply_check("R2 count 1");
      drive(64'd0, 2'(es), 2'b10);      apply_check("R1 count 0");
    end
    // R10: large 64-bit counts in every mode
    for (int md = 0; md < 4; md++) begin
      drive(64'h1_0000_0001, 2'b00, 2'(md)); apply_check("R10 count 2^32+1");
      drive('1, 2'b10, 2'(md));              apply_check("R10 count all-ones");
    end
    // R6 R7 R9: mode behaviour
    drive(64'd3, 2'b01, 2'b00); apply_check("R6 legacy upper kept");
    drive(64'd3, 2'b01, 2'b01); apply_check("R7 narrow upper zero");
    drive(64'd3, 2'b01, 2'b11); apply_check("R9 mode 11 zero");
    drive(64'd3, 2'b11, 2'b00); apply_check("R9 esize 11 legacy");
    drive(64'd3, 2'b11, 2'b10); apply_check("R9 esize 11 wide");
    // R4: upper count bits ignored
    drive(64'd5, 2'b00, 2'b10);
    cnt_vec[127:64] = '1;       apply_check("R4 upper count ones");
    @(negedge clk);
    cnt_vec[127:64] = 64'h0123_4567_89ab_cdef; apply_check("R4 upper count pattern");
    // R5: immediate count, operand ignored
    @(negedge clk);
    use_imm = 1'b1; imm = 8'd7; cnt_vec = '1; esize = 2'b00; mode = 2'b10;
    apply_check("R5 imm 7");
    @(negedge clk);
    imm = 8'd200; cnt_vec = '0; esize = 2'b10;
    apply_check("R5 imm 200");
    @(negedge clk);
    imm = 8'd63; cnt_vec = 128'd1;
    apply_check("R5 imm 63");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [63:0] c;
      int pick;
      @(negedge clk);
      src = rnd256(); prior = rnd256();
      pick = $urandom_range(0, 3);
      case (pick)
        0: c = 64'($urandom_range(0, 70));
        1: c = 64'((16 << $urandom_range(0, 2)) + $urandom_range(0, 2) - 1);
        2: c = {$urandom, $urandom};
        default: c = 64'($urandom_range(0, 15));
      endcase
      cnt_vec = {rnd256()[63:0], c};
      imm = 8'($urandom);
      use_imm = 1'($urandom);
      esize = 2'($urandom);
      mode = 2'($urandom);
      apply_check("R1 R3 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule